// File: doc/BRIEF.md
# Chained Double-Buffered DMA Channel

One DMA channel engine. It moves 32-bit words between a peripheral stream and a memory bus, one address segment at a time. Two address pairs are held on chip. The active pair is a running address and an exclusive end address. The queued pair is a start and a stop address. When the active segment ends, the queued pair can take its place in the same cycle, so a second segment follows the first with no idle gap.

Software drives the channel through a small word-indexed register file:

- The control/status word takes one-shot commands on write and reports flags on read.
- Software arms the queued pair with a queued-valid command.
- When a segment ends, the channel either swaps in the queued pair and keeps running, or drops its enable and stops. Each outcome leaves its own flag combination for the interrupt handler to decode.
- A bus error stops the channel and records the faulting address.

The memory side is a request/ready bus with an error input. The interrupt line is level-sensitive and follows the complete flag.

Top module: `dma_chain_chan`

## Requirements
- R1: Register index map on `cfg_addr`: 0 is control/status, 1 is running address, 2 is end address, 3 is queued start, 4 is queued stop, and 5..8 are the saved copies of running, end, start and stop. After power-on reset, the control/status word reads zero and `irq` is low.
- R2: Each accepted beat (`bus_req`, `bus_ready` and no `bus_err`) moves one word and advances the running address by 4.
  - Device-to-memory mode writes `pin_data` to `bus_addr` and pulses `pin_take`.
  - Memory-to-device mode presents `bus_rdata` on `pout_data` with `pout_valid`.
- R3: When the running address is at or past the end address and queued-valid is clear, complete sets, `irq` rises, enable clears, and no further bus request is made.
- R4: When the segment ends with queued-valid set, queued start and stop move into the running and end registers, queued-valid clears, enable stays set, and the next beat follows in the next cycle.
- R5: Command bits written to index 0: bit5 reset, bit4 clear-complete, bit3 device-to-memory, bit2 memory-to-device, bit1 set-queued-valid, bit0 set-enable.
  - Clear-complete drops complete and `irq`.
  - Reset clears enable, queued-valid, complete and bus-exception.
- R6: A beat answered with `bus_err` makes no transfer. It sets bus-exception and complete, clears enable, and stores the faulting address in the saved end copy.
- R7: At every segment end, the saved end copy (index 6) takes the address reached. The other saved copies hold what software last wrote to them.
- R8: Bit 31 of the end address is a marker and takes no part in the end compare; a parameter subtracts a fixed pad as well (zero by default).
- R9: Writes to the running and end registers are ignored while enable is set. The queued start and stop stay writable at all times.
- R10: A segment whose running address already equals its end address completes with no bus beat.
- R11: While a request waits for `bus_ready`, `bus_addr` holds its value.
- R12: Status bits read at index 0: bit0 enable, bit1 queued-valid, bit2 complete, bit3 bus-exception, bit4 direction (1 means memory-to-device). Direction is kept across a reset command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational on cfg_addr) |
| irq | output | 1 | Level interrupt, high while complete is set |
| pin_valid | input | 1 | Device has a word for memory |
| pin_data | input | 32 | Word from the device |
| pin_take | output | 1 | Device word consumed this cycle |
| pout_valid | output | 1 | Word for the device is valid this cycle |
| pout_data | output | 32 | Word to the device |
| bus_req | output | 1 | Memory beat request |
| bus_we | output | 1 | Beat is a memory write |
| bus_addr | output | 32 | Beat word address |
| bus_wdata | output | 32 | Beat write data |
| bus_rdata | input | 32 | Beat read data |
| bus_ready | input | 1 | Beat accepted this cycle |
| bus_err | input | 1 | Beat failed this cycle |

## Verification
The properties assume that the memory bus only answers while a request is up. They assume `bus_err` arrives together with `bus_ready`, and that software writes word-aligned addresses. The chain and stop checks also assume no control write lands in the very cycle a segment ends.

The stimulus keeps within these assumptions in three ways:
- Every control command is issued while the channel is idle, stalled by a held-low ready, or mid-way through a long segment.
- Errors are injected only on an address the engine is requesting.
- Every address pair is a multiple of four.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

  typedef enum logic [3:0] {
    RI_CSR      = 4'd0,
    RI_NEXT     = 4'd1,
    RI_LIMIT    = 4'd2,
    RI_START    = 4'd3,
    RI_STOP     = 4'd4,
    RI_SV_NEXT  = 4'd5,
    RI_SV_LIMIT = 4'd6,
    RI_SV_START = 4'd7,
    RI_SV_STOP  = 4'd8
  } reg_idx_e;

  localparam int unsigned CMD_W  = 6;
  localparam int unsigned STAT_W = 5;
  localparam int unsigned NUM_SV = 4;

  // command word, bit5 down to bit0
  typedef struct packed {
    logic rst;
    logic clr_done;
    logic to_mem;
    logic to_dev;
    logic set_qv;
    logic set_en;
  } csr_cmd_t;

  // status word, bit4 down to bit0
  typedef struct packed {
    logic dir;
    logic berr;
    logic done;
    logic qv;
    logic en;
  } csr_stat_t;

endpackage

// File: rtl/dma_chain_rst_sync.sv
module dma_chain_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/dma_chain_status.sv
module dma_chain_status
  import dma_chain_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cmd_we,
  input  csr_cmd_t  cmd,
  input  logic      seg_end,
  input  logic      beat_err,
  output csr_stat_t stat
);

  csr_stat_t stat_q;
  csr_stat_t stat_d;
  logic      stat_ce;

  always_comb begin
    stat_d  = stat_q;
    stat_ce = cmd_we | seg_end | beat_err;

    if (seg_end) begin
      stat_d.done = 1'b1;
      if (stat_q.qv) begin
        stat_d.qv = 1'b0;
      end else begin
        stat_d.en = 1'b0;
      end
    end

    if (beat_err) begin
      stat_d.done = 1'b1;
      stat_d.berr = 1'b1;
      stat_d.en   = 1'b0;
    end

    if (cmd_we) begin
      if (cmd.rst) begin
        stat_d.en   = 1'b0;
        stat_d.qv   = 1'b0;
        stat_d.done = 1'b0;
        stat_d.berr = 1'b0;
      end
      // a fresh end event in the same cycle keeps complete set
      if (cmd.clr_done && !(seg_end || beat_err)) begin
        stat_d.done = 1'b0;
      end
      if (cmd.set_en) begin
        stat_d.en = 1'b1;
      end
      if (cmd.set_qv) begin
        stat_d.qv = 1'b1;
      end
      if (cmd.to_dev) begin
        stat_d.dir = 1'b1;
      end
      if (cmd.to_mem) begin
        stat_d.dir = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (stat_ce) begin
      stat_q <= stat_d;
    end
  end

  assign stat = stat_q;

endmodule

// File: rtl/dma_chain_segregs.sv
module dma_chain_segregs
  import dma_chain_pkg::*;
#(
  parameter int unsigned AW   = 32,
  parameter int unsigned STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [3:0]    wr_idx,
  input  logic [AW-1:0] wr_data,
  input  logic          act_en,
  input  logic          queued_ok,
  input  logic          seg_end,
  input  logic          beat_ok,
  input  logic          beat_err,
  output logic [AW-1:0] next_q,
  output logic [AW-1:0] limit_q,
  output logic [AW-1:0] start_q,
  output logic [AW-1:0] stop_q,
  output logic [AW-1:0] sv_next_q,
  output logic [AW-1:0] sv_limit_q,
  output logic [AW-1:0] sv_start_q,
  output logic [AW-1:0] sv_stop_q
);

  logic          swap;
  logic          ld_next, ld_limit, ld_start, ld_stop;
  logic [AW-1:0] next_d, limit_d;

  assign swap = seg_end & queued_ok;

  always_comb begin
    ld_next  = 1'b0;
    next_d   = wr_data;
    ld_limit = 1'b0;
    limit_d  = wr_data;
    if (beat_ok) begin
      ld_next = 1'b1;
      next_d  = next_q + AW'(STEP);
    end else if (swap) begin
      ld_next = 1'b1;
      next_d  = start_q;
    end else if (wr_en && wr_idx == RI_NEXT && !act_en) begin
      ld_next = 1'b1;
    end
    if (swap) begin
      ld_limit = 1'b1;
      limit_d  = stop_q;
    end else if (wr_en && wr_idx == RI_LIMIT && !act_en) begin
      ld_limit = 1'b1;
    end
    ld_start = wr_en && wr_idx == RI_START;
    ld_stop  = wr_en && wr_idx == RI_STOP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_q <= '0;
    end else if (ld_next) begin
      next_q <= next_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_q <= '0;
    end else if (ld_limit) begin
      limit_q <= limit_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
    end else if (ld_start) begin
      start_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= '0;
    end else if (ld_stop) begin
      stop_q <= wr_data;
    end
  end

  // shadow copies; the saved end copy also records the address reached
  for (genvar i = 0; i < NUM_SV; i++) begin : g_sv
    logic          ld;
    logic [AW-1:0] d;
    logic [AW-1:0] q;

    always_comb begin
      ld = wr_en && (wr_idx == 4'(int'(RI_SV_NEXT) + i));
      d  = wr_data;
      if (i == 1 && (seg_end || beat_err)) begin
        ld = 1'b1;
        d  = next_q;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (ld) begin
        q <= d;
      end
    end
  end

  assign sv_next_q  = g_sv[0].q;
  assign sv_limit_q = g_sv[1].q;
  assign sv_start_q = g_sv[2].q;
  assign sv_stop_q  = g_sv[3].q;

endmodule

// File: rtl/dma_chain_mover.sv
module dma_chain_mover #(
  parameter int unsigned AW        = 32,
  parameter int unsigned DW        = 32,
  parameter bit          MASK_TOP  = 1'b1,
  parameter int unsigned PAD_BYTES = 0
) (
  input  logic          act_en,
  input  logic          to_dev,
  input  logic [AW-1:0] next_addr,
  input  logic [AW-1:0] limit_raw,
  input  logic          pin_valid,
  input  logic [DW-1:0] pin_data,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ready,
  input  logic          bus_err,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          pin_take,
  output logic          pout_valid,
  output logic [DW-1:0] pout_data,
  output logic          seg_end,
  output logic          beat_ok,
  output logic          beat_err
);

  localparam logic [AW-1:0] LIM_MASK = MASK_TOP ? {1'b0, {(AW-1){1'b1}}} : {AW{1'b1}};

  logic [AW-1:0] eff_limit;
  logic          want;

  assign eff_limit = (limit_raw & LIM_MASK) - AW'(PAD_BYTES);
  assign seg_end   = act_en && (next_addr >= eff_limit);
  assign want      = act_en && !seg_end && (to_dev || pin_valid);

  assign bus_req   = want;
  assign bus_we    = !to_dev;
  assign bus_addr  = next_addr;
  assign bus_wdata = pin_data;

  assign beat_ok   = want && bus_ready && !bus_err;
  assign beat_err  = want && bus_ready && bus_err;

  assign pin_take   = beat_ok && !to_dev;
  assign pout_valid = beat_ok && to_dev;
  assign pout_data  = bus_rdata;

endmodule

// File: rtl/dma_chain_chan.sv
module dma_chain_chan
  import dma_chain_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned DW        = 32,
  parameter bit          MASK_TOP  = 1'b1,
  parameter int unsigned PAD_BYTES = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [3:0]    cfg_addr,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] cfg_rdata,
  output logic          irq,
  input  logic          pin_valid,
  input  logic [DW-1:0] pin_data,
  output logic          pin_take,
  output logic          pout_valid,
  output logic [DW-1:0] pout_data,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ready,
  input  logic          bus_err
);

  localparam int unsigned STEP = DW / 8;

  logic          srst_n;
  logic          csr_we;
  csr_cmd_t      cmd;
  csr_stat_t     stat;
  logic          st_en, st_qv, st_done, st_berr, st_dir;
  logic          seg_end, beat_ok, beat_err;
  logic [AW-1:0] next_q, limit_q, start_q, stop_q;
  logic [AW-1:0] sv_next, sv_limit, sv_start, sv_stop;

  dma_chain_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  assign csr_we = cfg_we && (cfg_addr == RI_CSR);
  assign cmd    = csr_cmd_t'(cfg_wdata[CMD_W-1:0]);

  dma_chain_status u_stat (
    .clk      (clk),
    .rst_n    (srst_n),
    .cmd_we   (csr_we),
    .cmd      (cmd),
    .seg_end  (seg_end),
    .beat_err (beat_err),
    .stat     (stat)
  );

  assign st_en   = stat.en;
  assign st_qv   = stat.qv;
  assign st_done = stat.done;
  assign st_berr = stat.berr;
  assign st_dir  = stat.dir;

  dma_chain_segregs #(.AW(AW), .STEP(STEP)) u_regs (
    .clk        (clk),
    .rst_n      (srst_n),
    .wr_en      (cfg_we),
    .wr_idx     (cfg_addr),
    .wr_data    (cfg_wdata),
    .act_en     (st_en),
    .queued_ok  (st_qv),
    .seg_end    (seg_end),
    .beat_ok    (beat_ok),
    .beat_err   (beat_err),
    .next_q     (next_q),
    .limit_q    (limit_q),
    .start_q    (start_q),
    .stop_q     (stop_q),
    .sv_next_q  (sv_next),
    .sv_limit_q (sv_limit),
    .sv_start_q (sv_start),
    .sv_stop_q  (sv_stop)
  );

  dma_chain_mover #(
    .AW(AW), .DW(DW), .MASK_TOP(MASK_TOP), .PAD_BYTES(PAD_BYTES)
  ) u_mover (
    .act_en     (st_en),
    .to_dev     (st_dir),
    .next_addr  (next_q),
    .limit_raw  (limit_q),
    .pin_valid  (pin_valid),
    .pin_data   (pin_data),
    .bus_rdata  (bus_rdata),
    .bus_ready  (bus_ready),
    .bus_err    (bus_err),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .pin_take   (pin_take),
    .pout_valid (pout_valid),
    .pout_data  (pout_data),
    .seg_end    (seg_end),
    .beat_ok    (beat_ok),
    .beat_err   (beat_err)
  );

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      RI_CSR:      cfg_rdata = AW'({st_dir, st_berr, st_done, st_qv, st_en});
      RI_NEXT:     cfg_rdata = next_q;
      RI_LIMIT:    cfg_rdata = limit_q;
      RI_START:    cfg_rdata = start_q;
      RI_STOP:     cfg_rdata = stop_q;
      RI_SV_NEXT:  cfg_rdata = sv_next;
      RI_SV_LIMIT: cfg_rdata = sv_limit;
      RI_SV_START: cfg_rdata = sv_start;
      RI_SV_STOP:  cfg_rdata = sv_stop;
      default:     cfg_rdata = '0;
    endcase
  end

  assign irq = st_done;

endmodule

// File: rtl/dma_chain_chan_chk.sv
module dma_chain_chan_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [3:0]    cfg_addr,
  input logic [AW-1:0] cfg_wdata,
  input logic          bus_req,
  input logic          bus_ready,
  input logic          bus_err,
  input logic [AW-1:0] bus_addr,
  input logic          irq,
  input logic          st_en,
  input logic          st_qv,
  input logic          st_done,
  input logic          st_berr,
  input logic [AW-1:0] cur_next,
  input logic [AW-1:0] q_start,
  input logic [AW-1:0] sv_limit
);

  logic csr_wr;
  assign csr_wr = cfg_we && (cfg_addr == 4'd0);

  assert_beat_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ready && !bus_err) |=> (cur_next == $past(bus_addr) + 32'd4));

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !st_en |-> !bus_req);

  assert_stop_on_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(st_done) && !st_berr && !$past(st_qv) && !$past(cfg_we)) |-> !st_en);

  assert_chain_swap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(st_done) && !st_berr && $past(st_qv) && !$past(cfg_we))
      |-> (st_en && !st_qv && cur_next == $past(q_start)));

  assert_reset_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && cfg_wdata[5] && !cfg_wdata[0]) |=> (!irq && !st_en && !st_qv && !st_berr));

  assert_bus_error_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ready && bus_err && !csr_wr)
      |=> (st_berr && st_done && !st_en && sv_limit == $past(bus_addr)));

  assert_locked_next_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_en && !st_qv && cfg_we && cfg_addr == 4'd1 && !(bus_req && bus_ready))
      |=> (cur_next == $past(cur_next)));

  assert_addr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_req && !bus_ready) && bus_req) |-> $stable(bus_addr));

endmodule

bind dma_chain_chan dma_chain_chan_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_addr  (cfg_addr),
  .cfg_wdata (cfg_wdata),
  .bus_req   (bus_req),
  .bus_ready (bus_ready),
  .bus_err   (bus_err),
  .bus_addr  (bus_addr),
  .irq       (irq),
  .st_en     (st_en),
  .st_qv     (st_qv),
  .st_done   (st_done),
  .st_berr   (st_berr),
  .cur_next  (next_q),
  .q_start   (start_q),
  .sv_limit  (sv_limit)
);

// File: tb/dma_chain_chan_tb.sv
`timescale 1ns/1ps
module dma_chain_chan_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = 4'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic [31:0] cfg_rdata;
  logic        irq;
  logic        pin_take, pout_valid;
  logic [31:0] pout_data;
  logic        bus_req, bus_we;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic        bus_ready, bus_err;
  logic [31:0] src_cnt = 32'd0;
  logic        tog = 1'b0;
  int          rdy_mode = 0;
  logic        err_arm = 1'b0;
  logic [31:0] err_addr = 32'd0;

  int n_tot = 0;
  int n_fail = 0;
  logic [31:0] exp_cnt = 32'd0;
  bit finished = 1'b0;

  typedef struct {
    logic        we;
    logic [31:0] addr;
    logic [31:0] data;
  } beat_t;
  beat_t exp_q[$];

  always #2.5 clk = ~clk;

  assign bus_rdata = bus_addr ^ 32'h5A5A_0000;
  assign bus_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? tog : 1'b0;
  assign bus_err   = err_arm && (bus_addr == err_addr);

  always @(posedge clk) begin
    tog <= ~tog;
    if (pin_take) src_cnt <= src_cnt + 32'd1;
  end

  dma_chain_chan u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq),
    .pin_valid(1'b1), .pin_data(src_cnt), .pin_take(pin_take),
    .pout_valid(pout_valid), .pout_data(pout_data),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .bus_err(bus_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tot++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  // scoreboard monitor: every accepted beat must match the queue head
  always @(negedge clk) begin
    if (rst_n && bus_req && bus_ready && !bus_err) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected beat", bus_addr, 32'hFFFF_FFFF);
      end else begin
        beat_t e;
        e = exp_q.pop_front();
        chk(bus_addr == e.addr && bus_we == e.we, "R2 beat address/dir", bus_addr, e.addr);
        if (e.we) chk(bus_wdata == e.data && pin_take, "R2 write data", bus_wdata, e.data);
        else      chk(pout_data == e.data && pout_valid, "R2 device data", pout_data, e.data);
      end
    end
  end

  task automatic push_seg(input bit to_dev, input logic [31:0] b, input logic [31:0] l);
    for (logic [31:0] a = b; a < l; a += 32'd4) begin
      beat_t e;
      e.we   = !to_dev;
      e.addr = a;
      if (to_dev) e.data = a ^ 32'h5A5A_0000;
      else begin e.data = exp_cnt; exp_cnt++; end
      exp_q.push_back(e);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0; cfg_addr = 4'd0; cfg_wdata = 32'd0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] e, input string req);
    @(negedge clk);
    cfg_addr = a;
    #1;
    chk(cfg_rdata == e, req, cfg_rdata, e);
    cfg_addr = 4'd0;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (irq) return;
    end
    chk(1'b0, "R3 irq timeout", 32'd0, 32'd1);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      cfg_addr = 4'd0;
      #1;
      if (!cfg_rdata[0]) return;
    end
    chk(1'b0, "R3 idle timeout", 32'd1, 32'd0);
  endtask

  task automatic start_seg(input bit to_dev, input logic [31:0] n, input logic [31:0] l,
                           input bit qv, input logic [31:0] s, input logic [31:0] p);
    logic [31:0] dirb;
    dirb = to_dev ? 32'h04 : 32'h08;
    wr(4'd0, 32'h20 | dirb);
    wr(4'd0, 32'h00);
    wr(4'd1, n);
    wr(4'd2, l);
    if (qv) begin
      wr(4'd3, s);
      wr(4'd4, p);
    end
    wr(4'd0, 32'h01 | (qv ? 32'h02 : 32'h00) | dirb);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 power-on state
    rd_chk(4'd0, 32'h0, "R1 status after reset");
    chk(irq == 1'b0, "R1 irq after reset", 32'(irq), 32'd0);

    // R4 chained device-to-memory segments
    push_seg(1'b0, 32'h100, 32'h110);
    push_seg(1'b0, 32'h200, 32'h208);
    start_seg(1'b0, 32'h100, 32'h110, 1'b1, 32'h200, 32'h208);
    wait_irq();
    #1 cfg_addr = 4'd0;
    #0.5 chk(cfg_rdata == 32'h05, "R4 status after swap", cfg_rdata, 32'h05);
    wait_idle();
    rd_chk(4'd0, 32'h04, "R3 status after final end");
    rd_chk(4'd6, 32'h208, "R7 saved end copy");
    rd_chk(4'd1, 32'h208, "R4 running address after chain");

    // R5 clear-complete
    wr(4'd0, 32'h18);
    chk(irq == 1'b0, "R5 irq after clear-complete", 32'(irq), 32'd0);

    // R2 R12 memory-to-device with a stuttering bus
    rdy_mode = 1;
    push_seg(1'b1, 32'h1000, 32'h1010);
    start_seg(1'b1, 32'h1000, 32'h1010, 1'b0, 32'h0, 32'h0);
    wait_idle();
    rd_chk(4'd0, 32'h14, "R12 status with direction bit");
    chk(irq == 1'b1, "R3 irq level", 32'(irq), 32'd1);

    // R9 R11 locked registers while stalled
    rdy_mode = 2;
    start_seg(1'b1, 32'h2000, 32'h2040, 1'b0, 32'h0, 32'h0);
    wr(4'd1, 32'hABC0);
    rd_chk(4'd1, 32'h2000, "R9 running address locked");
    wr(4'd2, 32'h9990);
    rd_chk(4'd2, 32'h2040, "R9 end address locked");
    wr(4'd3, 32'h3000);
    rd_chk(4'd3, 32'h3000, "R9 queued start writable");
    chk(bus_req && bus_addr == 32'h2000, "R11 address held while stalled", bus_addr, 32'h2000);
    wr(4'd0, 32'h30);
    rd_chk(4'd0, 32'h10, "R5 reset command shuts down");
    chk(bus_req == 1'b0, "R5 no request after shutdown", 32'(bus_req), 32'd0);
    rdy_mode = 0;

    // R8 marker bit in end address
    push_seg(1'b0, 32'h300, 32'h308);
    start_seg(1'b0, 32'h300, 32'h8000_0308, 1'b0, 32'h0, 32'h0);
    wait_idle();
    rd_chk(4'd0, 32'h04, "R8 status after marked end");
    rd_chk(4'd6, 32'h308, "R8 saved end ignores marker");

    // R6 bus error
    err_arm = 1'b1; err_addr = 32'h408;
    push_seg(1'b0, 32'h400, 32'h408);
    start_seg(1'b0, 32'h400, 32'h410, 1'b0, 32'h0, 32'h0);
    wait_idle();
    err_arm = 1'b0;
    rd_chk(4'd0, 32'h0C, "R6 error status");
    rd_chk(4'd6, 32'h408, "R6 fault address");

    // R10 zero-length segment
    start_seg(1'b0, 32'h500, 32'h500, 1'b0, 32'h0, 32'h0);
    wait_idle();
    rd_chk(4'd0, 32'h04, "R10 zero-length completes");
    rd_chk(4'd1, 32'h500, "R10 no beat taken");

    // R7 shadow copy written by software
    wr(4'd5, 32'h1234);
    rd_chk(4'd5, 32'h1234, "R7 saved running copy");

    // R4 refill of the queued pair from the interrupt
    push_seg(1'b0, 32'h600, 32'h610);
    push_seg(1'b0, 32'h700, 32'h740);
    push_seg(1'b0, 32'h800, 32'h808);
    start_seg(1'b0, 32'h600, 32'h610, 1'b1, 32'h700, 32'h740);
    wait_irq();
    wr(4'd3, 32'h800);
    wr(4'd4, 32'h808);
    wr(4'd0, 32'h1A);
    wait_idle();
    rd_chk(4'd0, 32'h04, "R4 refilled chain ends");
    rd_chk(4'd6, 32'h808, "R7 saved end after refill");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all expected beats seen", 32'(exp_q.size()), 32'd0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tot++;
      n_fail++;
      $display("FAIL watchdog R3 actual=hung expected=done");
      $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
      $finish;
    end
  end

endmodule